// File: doc/BRIEF.md
# Serial Adapter Register Interface

This block is the processor-side register file of a byte-oriented asynchronous serial adapter. A CPU reaches four byte-wide registers through a two-bit address with separate read and write strobes. The line side is a byte interface: an incoming byte arrives as a one-cycle valid pulse with data, and an outgoing byte leaves the same way. There are no FIFOs and no bit timing. Exactly one byte is held in each direction, and a status register tells software what is waiting and what went wrong.

Reads have side effects. Reading status hands back a snapshot and then clears the interrupt and error flags. Reading the data register consumes the received byte. A byte written by the CPU goes out on the line port on the following clock. An echo mode loops every received byte straight back out. Interrupts can be raised when a byte arrives and when a transmit completes. The interrupt pin is a registered copy of the internal interrupt flag.

Top module: `serial_adapter_regs`

## Requirements
- R1: Hardware reset (synchronous, active high) zeroes the command, control, receive and transmit registers and the read-data output. It clears receive-full, overrun, the interrupt flag, the irq pin and tx_valid, and sets transmit-empty, so a status read afterwards returns 0x50.
- R2: Address 0 is data, 1 is status (read) or programmed reset (write), 2 is command and 3 is control. Command and control read back what was written. cpu_rdata shows the selected register in the cycle after the read strobe, and it keeps that value until the next read.
- R3: Status layout: bit 0 parity error and bit 1 framing error always read 0, bit 2 overrun, bit 3 receive-full, bit 4 transmit-empty, bit 5 always 0, bit 6 always 1, bit 7 interrupt flag.
- R4: A received byte is stored and sets receive-full. If receive-full was already set and the held byte is not read in that same cycle, overrun is set and the new byte replaces the old one.
- R5: A status read returns the flags as they stood before the read. It then clears the interrupt flag and overrun, and leaves receive-full unchanged.
- R6: A data read returns the held byte and clears receive-full, overrun and the interrupt flag. If a new byte arrives in the same cycle, receive-full stays set and no overrun is flagged.
- R7: When command bit 1 is 0, every received byte sets the interrupt flag. When it is 1, received bytes do not set it.
- R8: A CPU write to data clears transmit-empty and makes the byte pending. On the next clock the byte appears on tx_data with a one-cycle tx_valid pulse, and transmit-empty is set again.
- R9: When command bits 3:2 equal 01, completing a CPU transmit sets the interrupt flag.
- R10: When command bit 4 is 1, each received byte is driven on the transmit port one cycle later. The echo does not change transmit-empty.
- R11: If an echo and a pending CPU byte want the transmit port on the same clock, the echo goes out first and the CPU byte goes out on the following clock.
- R12: A write to address 1 cancels a pending CPU transmit so that nothing is emitted for it. It sets transmit-empty and clears overrun, and it leaves receive-full and the held byte unchanged.
- R13: The irq pin equals the interrupt flag one cycle later. When a set event and a clearing read happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register select |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Registered active-high interrupt |

## Verification
On every clock the assertions check a fixed set of properties. The irq pin must trail the internal flag by exactly one cycle. The constant status bits must hold on every status read. An unread arrival into a full holding register must raise overrun, and an echo must reproduce the received byte. A programmed reset must leave the transmit port idle, and a data write must clear transmit-empty. Several behaviours appear only in the bench scenarios: the read-to-clear ordering, where set events win over clearing reads in the same cycle; the echo-versus-CPU ordering on the transmit port; the interrupt enables; and the full reset state.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_CTL  = 2'd3
  } reg_sel_e;

  // status bit positions (software decodes these)
  localparam int ST_PAR  = 0;
  localparam int ST_FRM  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_RXF  = 3;
  localparam int ST_TXE  = 4;
  localparam int ST_DCD  = 5;
  localparam int ST_DSR  = 6;
  localparam int ST_IRQ  = 7;

  // command bit positions
  localparam int CMD_RXI_OFF = 1;
  localparam int CMD_TIC_LO  = 2;
  localparam int CMD_TIC_HI  = 3;
  localparam int CMD_ECHO    = 4;

  localparam logic [1:0] TIC_TX_IRQ = 2'b01;

  function automatic logic [7:0] pack_status(
    input logic irq_f,
    input logic txe,
    input logic rxf,
    input logic ovr
  );
    logic [7:0] s;
    s         = '0;
    s[ST_PAR] = 1'b0;
    s[ST_FRM] = 1'b0;
    s[ST_OVR] = ovr;
    s[ST_RXF] = rxf;
    s[ST_TXE] = txe;
    s[ST_DCD] = 1'b0;
    s[ST_DSR] = 1'b1;
    s[ST_IRQ] = irq_f;
    return s;
  endfunction

endpackage

// File: rtl/sar_rx_hold.sv
`timescale 1ns/1ps
module sar_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              consume,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_full,
  output logic              rx_ovr
);

  // an arrival collides only if the old byte is still unread
  logic collide;
  assign collide = rx_full & ~consume;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else if (rx_valid) begin
      rx_byte <= rx_data;
      rx_full <= 1'b1;
      if (collide)
        rx_ovr <= 1'b1;
      else if (consume || ovr_clr)
        rx_ovr <= 1'b0;
    end else begin
      if (consume) begin
        rx_full <= 1'b0;
        rx_ovr  <= 1'b0;
      end else if (ovr_clr) begin
        rx_ovr  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sar_tx_hold.sv
`timescale 1ns/1ps
module sar_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              cancel,
  input  logic              echo_go,
  input  logic [DATA_W-1:0] echo_byte,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  output logic              tx_done
);

  logic              pend;
  logic [DATA_W-1:0] hold;

  // the CPU byte leaves only when the port is not taken by an echo
  assign tx_done = pend & ~echo_go & ~cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      hold     <= '0;
      pend     <= 1'b0;
      tx_empty <= 1'b1;
    end else begin
      tx_valid <= echo_go | tx_done;
      if (echo_go)
        tx_data <= echo_byte;
      else if (tx_done)
        tx_data <= hold;

      if (load) begin
        hold     <= load_byte;
        pend     <= 1'b1;
        tx_empty <= 1'b0;
      end else if (cancel || tx_done) begin
        pend     <= 1'b0;
        tx_empty <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_irq_ctl.sv
`timescale 1ns/1ps
module sar_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_rx,
  input  logic set_tx,
  input  logic clr,
  output logic irq_flag,
  output logic irq_pin
);

  logic set_any;
  assign set_any = set_rx | set_tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag <= 1'b0;
      irq_pin  <= 1'b0;
    end else begin
      if (set_any)
        irq_flag <= 1'b1;
      else if (clr)
        irq_flag <= 1'b0;
      irq_pin <= irq_flag;
    end
  end

endmodule

// File: rtl/serial_adapter_regs.sv
`timescale 1ns/1ps
module serial_adapter_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);
  import sar_pkg::*;

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(SEL_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(SEL_STAT);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(SEL_CMD);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(SEL_CTL);

  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] ctl_q;

  logic wr_data, wr_prst, wr_cmd, wr_ctl;
  logic rd_data, rd_stat;

  assign wr_data = cpu_wr && (cpu_addr == A_DATA);
  assign wr_prst = cpu_wr && (cpu_addr == A_STAT);
  assign wr_cmd  = cpu_wr && (cpu_addr == A_CMD);
  assign wr_ctl  = cpu_wr && (cpu_addr == A_CTL);
  assign rd_data = cpu_rd && (cpu_addr == A_DATA);
  assign rd_stat = cpu_rd && (cpu_addr == A_STAT);

  logic [DATA_W-1:0] rx_byte;
  logic              rx_full;
  logic              rx_ovr;
  logic              tx_empty;
  logic              tx_done;
  logic              irq_flag;
  logic              echo_go;
  logic              set_rx, set_tx;

  assign echo_go = rx_valid & cmd_q[CMD_ECHO];
  assign set_rx  = rx_valid & ~cmd_q[CMD_RXI_OFF];
  assign set_tx  = tx_done & (cmd_q[CMD_TIC_HI:CMD_TIC_LO] == TIC_TX_IRQ);

  sar_rx_hold #(.DATA_W(DATA_W)) rx_i (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .consume  (rd_data),
    .ovr_clr  (rd_stat | wr_prst),
    .rx_byte  (rx_byte),
    .rx_full  (rx_full),
    .rx_ovr   (rx_ovr)
  );

  sar_tx_hold #(.DATA_W(DATA_W)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .load      (wr_data),
    .load_byte (cpu_wdata),
    .cancel    (wr_prst),
    .echo_go   (echo_go),
    .echo_byte (rx_data),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_empty  (tx_empty),
    .tx_done   (tx_done)
  );

  sar_irq_ctl irq_i (
    .clk      (clk),
    .rst      (rst),
    .set_rx   (set_rx),
    .set_tx   (set_tx),
    .clr      (rd_data | rd_stat),
    .irq_flag (irq_flag),
    .irq_pin  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= cpu_wdata;
      if (wr_ctl) ctl_q <= cpu_wdata;
    end
  end

  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_mux;

  assign status_w = DATA_W'(pack_status(irq_flag, tx_empty, rx_full, rx_ovr));

  always_comb begin
    unique case (cpu_addr)
      A_DATA:  rd_mux = rx_byte;
      A_STAT:  rd_mux = status_w;
      A_CMD:   rd_mux = cmd_q;
      A_CTL:   rd_mux = ctl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      cpu_rdata <= '0;
    else if (cpu_rd)
      cpu_rdata <= rd_mux;
  end

endmodule

// File: rtl/sar_checker.sv
`timescale 1ns/1ps
module sar_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              irq,
  input logic              irq_flag,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              rx_ovr,
  input logic [DATA_W-1:0] cmd_q
);

  logic rst_seen = 1'b1;
  always_ff @(posedge clk) rst_seen <= rst;

  assert_irq_lag_R13: assert property (@(posedge clk) disable iff (rst || rst_seen)
    irq == $past(irq_flag));

  assert_status_const_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == ADDR_W'(1)) |=>
      (cpu_rdata[6] && !cpu_rdata[5] && cpu_rdata[1:0] == 2'b00));

  assert_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_full && !(cpu_rd && cpu_addr == ADDR_W'(0))) |=> (rx_ovr && rx_full));

  assert_consume_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == ADDR_W'(0) && !rx_valid) |=> (!rx_full && !rx_ovr));

  assert_echo_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cmd_q[4]) |=> (tx_valid && tx_data == $past(rx_data)));

  assert_prog_reset_R12: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == ADDR_W'(1) && !(rx_valid && cmd_q[4])) |=> (!tx_valid && tx_empty));

  assert_tx_load_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == ADDR_W'(0)) |=> !tx_empty);

endmodule

bind serial_adapter_regs sar_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .rx_valid  (rx_valid),
  .rx_data   (rx_data),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .irq       (irq),
  .irq_flag  (irq_flag),
  .tx_empty  (tx_empty),
  .rx_full   (rx_full),
  .rx_ovr    (rx_ovr),
  .cmd_q     (cmd_q)
);

// File: tb/serial_adapter_regs_tb_top.sv
`timescale 1ns/1ps
module serial_adapter_regs_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cpu_addr = '0;
  logic       cpu_rd = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       irq;

  always #2.5 clk = ~clk;

  serial_adapter_regs dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected<%0d", cyc, 20000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    step();
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    cpu_addr = a; cpu_rd = 1'b1;
    step();
    cpu_rd = 1'b0;
  endtask

  task automatic rx(input logic [7:0] d);
    rx_data = d; rx_valid = 1'b1;
    step();
    rx_valid = 1'b0;
  endtask

  // {op, addr, data, expected}; op 1 write, 2 read-and-compare, 3 line receive
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 2'd2, 8'h02, 8'h00},
    {2'd1, 2'd3, 8'h1F, 8'h00},
    {2'd2, 2'd3, 8'h00, 8'h1F},
    {2'd2, 2'd2, 8'h00, 8'h02},
    {2'd2, 2'd1, 8'h00, 8'h50},
    {2'd3, 2'd0, 8'hA5, 8'h00},
    {2'd2, 2'd1, 8'h00, 8'h58},
    {2'd3, 2'd0, 8'h3C, 8'h00},
    {2'd2, 2'd1, 8'h00, 8'h5C},
    {2'd2, 2'd1, 8'h00, 8'h58},
    {2'd2, 2'd0, 8'h00, 8'h3C},
    {2'd2, 2'd1, 8'h00, 8'h50},
    {2'd1, 2'd0, 8'h77, 8'h00},
    {2'd2, 2'd1, 8'h00, 8'h40},
    {2'd2, 2'd1, 8'h00, 8'h50},
    {2'd1, 2'd2, 8'h06, 8'h00},
    {2'd1, 2'd0, 8'h11, 8'h00},
    {2'd2, 2'd2, 8'h00, 8'h06},
    {2'd2, 2'd1, 8'h00, 8'hD0},
    {2'd2, 2'd1, 8'h00, 8'h50}
  };

  initial begin
    step(); step(); step();
    chk("R1 rdata at reset", cpu_rdata, 8'h00);
    chk("R1 tx_valid at reset", {7'd0, tx_valid}, 8'h00);
    chk("R1 irq at reset", {7'd0, irq}, 8'h00);
    rst = 1'b0;
    rd(2'd1); chk("R1 R3 status after reset", cpu_rdata, 8'h50);
    rd(2'd2); chk("R1 command after reset", cpu_rdata, 8'h00);

    // table walk: map, status layout, overrun, tx timing, tx interrupt
    for (int i = 0; i < NV; i++) begin
      cpu_addr = VEC[i][17:16];
      case (VEC[i][19:18])
        2'd1: begin cpu_wdata = VEC[i][15:8]; cpu_wr = 1'b1; end
        2'd2: cpu_rd = 1'b1;
        2'd3: begin rx_data = VEC[i][15:8]; rx_valid = 1'b1; end
        default: ;
      endcase
      step();
      cpu_wr = 1'b0; cpu_rd = 1'b0; rx_valid = 1'b0;
      if (VEC[i][19:18] == 2'd2)
        chk($sformatf("R2 vector %0d", i), cpu_rdata, VEC[i][7:0]);
    end

    // R8 transmit timing on the port
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h77);
    chk("R8 no emit at load edge", {7'd0, tx_valid}, 8'h00);
    step();
    chk("R8 emit pulse", {7'd0, tx_valid}, 8'h01);
    chk("R8 emitted byte", tx_data, 8'h77);
    step();
    chk("R8 pulse ends", {7'd0, tx_valid}, 8'h00);

    // R7 and R13 receive interrupt, pin lag
    wr(2'd2, 8'h00);
    rx(8'h21);
    chk("R13 pin lags flag", {7'd0, irq}, 8'h00);
    step();
    chk("R7 rx interrupt raised", {7'd0, irq}, 8'h01);
    rd(2'd0);
    chk("R6 data read value", cpu_rdata, 8'h21);
    chk("R13 pin still high", {7'd0, irq}, 8'h01);
    step();
    chk("R6 R13 irq cleared by data read", {7'd0, irq}, 8'h00);

    // R13 set beats a clearing status read; R4 overrun
    rx(8'h30);
    step();
    cpu_addr = 2'd1; cpu_rd = 1'b1; rx_data = 8'h31; rx_valid = 1'b1;
    step();
    cpu_rd = 1'b0; rx_valid = 1'b0;
    chk("R5 status snapshot", cpu_rdata, 8'hD8);
    step();
    chk("R13 set wins over clear", {7'd0, irq}, 8'h01);
    rd(2'd1); chk("R4 overrun flagged", cpu_rdata, 8'hDC);
    rd(2'd0); chk("R4 newest byte kept", cpu_rdata, 8'h31);
    rd(2'd1); chk("R5 flags cleared", cpu_rdata, 8'h50);

    // R6 data read with same-cycle arrival
    wr(2'd2, 8'h02);
    rx(8'h41);
    cpu_addr = 2'd0; cpu_rd = 1'b1; rx_data = 8'h42; rx_valid = 1'b1;
    step();
    cpu_rd = 1'b0; rx_valid = 1'b0;
    chk("R6 old byte returned", cpu_rdata, 8'h41);
    rd(2'd1); chk("R6 full kept, no overrun", cpu_rdata, 8'h58);
    rd(2'd0); chk("R6 new byte held", cpu_rdata, 8'h42);

    // R10 echo
    wr(2'd2, 8'h12);
    rx(8'h5A);
    chk("R10 echo pulse", {7'd0, tx_valid}, 8'h01);
    chk("R10 echo byte", tx_data, 8'h5A);
    rd(2'd1); chk("R10 echo leaves tx empty", cpu_rdata, 8'h58);
    rd(2'd0);

    // R11 echo before pending CPU byte
    wr(2'd0, 8'hC3);
    chk("R11 nothing at load edge", {7'd0, tx_valid}, 8'h00);
    rx(8'h99);
    chk("R11 echo first", tx_data, 8'h99);
    chk("R11 echo valid", {7'd0, tx_valid}, 8'h01);
    step();
    chk("R11 cpu byte next", tx_data, 8'hC3);
    chk("R11 cpu valid", {7'd0, tx_valid}, 8'h01);
    step();
    chk("R11 port idle", {7'd0, tx_valid}, 8'h00);
    rd(2'd0);

    // R12 programmed reset
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h44);
    wr(2'd1, 8'h00);
    chk("R12 cancelled emit", {7'd0, tx_valid}, 8'h00);
    step();
    chk("R12 still idle", {7'd0, tx_valid}, 8'h00);
    rd(2'd1); chk("R12 tx empty again", cpu_rdata, 8'h50);
    rx(8'h01); rx(8'h02);
    wr(2'd1, 8'h00);
    rd(2'd1); chk("R12 overrun cleared, full kept", cpu_rdata, 8'h58);
    rd(2'd0); chk("R12 held byte kept", cpu_rdata, 8'h02);

    // R9 transmit-complete interrupt
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h10);
    step();
    step();
    chk("R9 tx interrupt pin", {7'd0, irq}, 8'h01);
    rd(2'd1); chk("R9 status irq bit", cpu_rdata, 8'hD0);
    step();
    chk("R9 irq cleared", {7'd0, irq}, 8'h00);

    // R1 hardware reset mid-run
    wr(2'd3, 8'hAB);
    rx(8'h55);
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 rdata cleared", cpu_rdata, 8'h00);
    rd(2'd3); chk("R1 control cleared", cpu_rdata, 8'h00);
    rd(2'd1); chk("R1 status after reset", cpu_rdata, 8'h50);
    chk("R1 irq low", {7'd0, irq}, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule